// File: doc/BRIEF.md
# Text Console Character Writer

This block turns a stream of byte-wide characters into cell writes for an 80 x 25 text screen held in an external single-port cell RAM. Each cell is a 16-bit word. Bits [7:0] hold the character code and bits [15:8] hold the colour attribute. The block keeps the current row and column and interprets a small set of control codes. It wraps at the end of a line and scrolls the screen up by one row when output runs past the last line.

After each character the block reports the linear cursor offset. It does this with two byte writes to a cursor-position register pair.

A clear command blanks the whole screen with spaces in the current attribute. An attribute input changes the colour used for the characters that follow. Characters enter over a valid/ready handshake. Ready drops while a cell write, a scroll copy, a clear fill or the cursor update is in progress.

Top module: `con_writer`

## Requirements
- R1: After reset, chr_ready_o is high, no RAM or cursor write is issued, the position is row 0 / column 0, and the current attribute is 0x07.
- R2: Any code not listed in R3 to R5 is printable. It is written to cell row*80+col as {attribute, code}, and the column then advances. Advancing past column 79 moves to column 0 of the next row.
- R3: Line feed (0x0A) sets the column to 0 and advances the row. Carriage return (0x0D) sets the column to 0 and leaves the row as it is.
- R4: Tab (0x09) moves the column to col+8-(col mod 8). A result of 80 or more becomes column 0 of the next row.
- R5: Backspace (0x08) decrements a nonzero column. At column 0 it changes nothing and writes no cursor register. Bell (0x07) changes no cell and no position.
- R6: When the row would pass 24, cells 80..1999 are copied to 0..1919 by read-then-write, one cell at a time. Cells 1920..1999 are then filled with 0x20 in the attribute of the character that caused the scroll, and the row stays 24.
- R7: After every accepted character except an ignored backspace, the cursor offset row*80+col is written as two writes on consecutive cycles: register index 14 with offset bits [15:8], then register index 15 with offset bits [7:0].
- R8: A clear (clr_i high while idle) fills all 2000 cells with 0x20 and the current attribute, resets the position to 0 and writes the cursor pair. A character offered in the same cycle as a clear is not accepted.
- R9: attr_we_i loads attr_i as the attribute for later characters. A character accepted in the same cycle still uses the previous attribute.
- R10: chr_ready_o is low whenever a RAM access or a cursor write is in progress, so no character is accepted before the current one's writes, scroll and cursor update finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chr_valid_i | input | 1 | Character offered |
| chr_i | input | 8 | Character code |
| chr_ready_o | output | 1 | Character accepted when high together with valid |
| clr_i | input | 1 | Clear-screen command, taken when idle |
| attr_we_i | input | 1 | Load a new current attribute |
| attr_i | input | 8 | Attribute value |
| mem_we_o | output | 1 | Cell RAM write strobe |
| mem_re_o | output | 1 | Cell RAM read strobe (data returned next cycle) |
| mem_addr_o | output | $clog2(COLS*ROWS) (11) | Cell index |
| mem_wdata_o | output | 16 | Cell word {attribute, character} |
| mem_rdata_i | input | 16 | Cell read data, one cycle after mem_re_o |
| curs_we_o | output | 1 | Cursor register write strobe |
| curs_idx_o | output | 8 | Cursor register index (14 high byte, 15 low byte) |
| curs_data_o | output | 8 | Cursor offset byte |

## Verification
Two events can meet in one clock edge. The first is an attribute load arriving together with a character acceptance. The bench drives both in the same cycle and expects the character in the old attribute and the next character in the new one. The second is a clear command raised together with a valid character. The bench holds the character valid only for that cycle and expects a blank screen, with no trace of the character and a cursor offset of 0. Both are judged against a bench screen model that is compared cell by cell.

// File: rtl/con_pkg.sv
package con_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUT, ST_SC_RD, ST_SC_WR, ST_FILL, ST_CUR_HI, ST_CUR_LO
  } con_state_e;

  localparam logic [7:0] CH_BEL   = 8'h07;
  localparam logic [7:0] CH_BS    = 8'h08;
  localparam logic [7:0] CH_TAB   = 8'h09;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_SPACE = 8'h20;

  localparam logic [7:0] CURS_IDX_HI = 8'd14;
  localparam logic [7:0] CURS_IDX_LO = 8'd15;
  localparam logic [7:0] ATTR_RST    = 8'h07;
endpackage

// File: rtl/con_pos_step.sv
// Next cursor position for one character; row clamps at the last line and flags overflow.
module con_pos_step
  import con_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  parameter int TAB  = 8,
  parameter int RW   = 5,
  parameter int CW   = 7
) (
  input  logic [RW-1:0] row_i,
  input  logic [CW-1:0] col_i,
  input  logic [7:0]    ch_i,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          print_o,
  output logic          skip_o,
  output logic          ovf_o
);
  logic [RW-1:0] r;
  logic [CW-1:0] c;
  logic [CW-1:0] tab_c;

  assign tab_c = col_i + CW'(TAB) - (col_i % CW'(TAB));

  always_comb begin
    r       = row_i;
    c       = col_i;
    print_o = 1'b0;
    skip_o  = 1'b0;
    unique case (ch_i)
      CH_LF: begin
        c = '0;
        r = row_i + RW'(1);
      end
      CH_CR:  c = '0;
      CH_BEL: ;
      CH_TAB: begin
        if (tab_c >= CW'(COLS)) begin
          c = '0;
          r = row_i + RW'(1);
        end else begin
          c = tab_c;
        end
      end
      CH_BS: begin
        if (col_i != '0) c = col_i - CW'(1);
        else skip_o = 1'b1;
      end
      default: begin
        print_o = 1'b1;
        if (col_i + CW'(1) >= CW'(COLS)) begin
          c = '0;
          r = row_i + RW'(1);
        end else begin
          c = col_i + CW'(1);
        end
      end
    endcase
    ovf_o = (r >= RW'(ROWS));
    row_o = ovf_o ? RW'(ROWS - 1) : r;
    col_o = c;
  end
endmodule

// File: rtl/con_cell_idx.sv
module con_cell_idx #(
  parameter int COLS = 80,
  parameter int RW   = 5,
  parameter int CW   = 7,
  parameter int AW   = 11
) (
  input  logic [RW-1:0] row_i,
  input  logic [CW-1:0] col_i,
  output logic [AW-1:0] idx_o
);
  assign idx_o = AW'(row_i) * AW'(COLS) + AW'(col_i);
endmodule

// File: rtl/con_writer.sv
module con_writer
  import con_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  parameter int TAB  = 8,
  localparam int AW  = $clog2(COLS * ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chr_valid_i,
  input  logic [7:0]    chr_i,
  output logic          chr_ready_o,
  input  logic          clr_i,
  input  logic          attr_we_i,
  input  logic [7:0]    attr_i,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  output logic          curs_we_o,
  output logic [7:0]    curs_idx_o,
  output logic [7:0]    curs_data_o
);
  localparam int CELLS = COLS * ROWS;
  localparam int RW    = $clog2(ROWS + 1);
  localparam int CW    = $clog2(COLS + TAB + 1);
  localparam logic [AW-1:0] LAST_CELL = AW'(CELLS - 1);
  localparam logic [AW-1:0] LAST_ROW0 = AW'(CELLS - COLS);

  con_state_e    state_q;
  logic [RW-1:0] row_q, nx_row;
  logic [CW-1:0] col_q, nx_col;
  logic [7:0]    attr_q, lat_attr_q, lat_ch_q;
  logic [AW-1:0] cell_q, ptr_q, cur_idx;
  logic          scroll_q;
  logic          nx_print, nx_skip, nx_ovf;
  logic          accept;
  logic [15:0]   off16;

  con_pos_step #(
    .COLS(COLS), .ROWS(ROWS), .TAB(TAB), .RW(RW), .CW(CW)
  ) i_step (
    .row_i  (row_q),
    .col_i  (col_q),
    .ch_i   (chr_i),
    .row_o  (nx_row),
    .col_o  (nx_col),
    .print_o(nx_print),
    .skip_o (nx_skip),
    .ovf_o  (nx_ovf)
  );

  con_cell_idx #(
    .COLS(COLS), .RW(RW), .CW(CW), .AW(AW)
  ) i_idx (
    .row_i(row_q),
    .col_i(col_q),
    .idx_o(cur_idx)
  );

  // clear wins over a character offered in the same cycle
  assign chr_ready_o = (state_q == ST_IDLE) && !clr_i;
  assign accept      = chr_valid_i && chr_ready_o;
  assign off16       = 16'(cur_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) attr_q <= ATTR_RST;
    else if (attr_we_i) attr_q <= attr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      lat_attr_q <= ATTR_RST;
      lat_ch_q   <= '0;
      cell_q     <= '0;
      ptr_q      <= '0;
      scroll_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (clr_i) begin
            lat_attr_q <= attr_q;
            row_q      <= '0;
            col_q      <= '0;
            ptr_q      <= '0;
            state_q    <= ST_FILL;
          end else if (accept) begin
            lat_attr_q <= attr_q;
            lat_ch_q   <= chr_i;
            cell_q     <= cur_idx;
            row_q      <= nx_row;
            col_q      <= nx_col;
            scroll_q   <= nx_ovf;
            ptr_q      <= AW'(COLS);
            if (nx_print)    state_q <= ST_PUT;
            else if (nx_skip) state_q <= ST_IDLE;
            else if (nx_ovf)  state_q <= ST_SC_RD;
            else              state_q <= ST_CUR_HI;
          end
        end
        ST_PUT:   state_q <= scroll_q ? ST_SC_RD : ST_CUR_HI;
        ST_SC_RD: state_q <= ST_SC_WR;
        ST_SC_WR: begin
          if (ptr_q == LAST_CELL) begin
            ptr_q   <= LAST_ROW0;
            state_q <= ST_FILL;
          end else begin
            ptr_q   <= ptr_q + AW'(1);
            state_q <= ST_SC_RD;
          end
        end
        ST_FILL: begin
          if (ptr_q == LAST_CELL) state_q <= ST_CUR_HI;
          else ptr_q <= ptr_q + AW'(1);
        end
        ST_CUR_HI: state_q <= ST_CUR_LO;
        ST_CUR_LO: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_addr_o  = ptr_q;
    mem_wdata_o = {lat_attr_q, CH_SPACE};
    curs_we_o   = 1'b0;
    curs_idx_o  = CURS_IDX_HI;
    curs_data_o = off16[15:8];
    unique case (state_q)
      ST_PUT: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = cell_q;
        mem_wdata_o = {lat_attr_q, lat_ch_q};
      end
      ST_SC_RD: mem_re_o = 1'b1;
      ST_SC_WR: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr_q - AW'(COLS);
        mem_wdata_o = mem_rdata_i;
      end
      ST_FILL:   mem_we_o = 1'b1;
      ST_CUR_HI: curs_we_o = 1'b1;
      ST_CUR_LO: begin
        curs_we_o   = 1'b1;
        curs_idx_o  = CURS_IDX_LO;
        curs_data_o = off16[7:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/con_writer_chk.sv
module con_writer_chk #(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  parameter int AW   = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          chr_valid_i,
  input logic [7:0]    chr_i,
  input logic          chr_ready_o,
  input logic          clr_i,
  input logic          attr_we_i,
  input logic [7:0]    attr_i,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [15:0]   mem_wdata_o,
  input logic [15:0]   mem_rdata_i,
  input logic          curs_we_o,
  input logic [7:0]    curs_idx_o,
  input logic [7:0]    curs_data_o
);
  localparam int CELLS = COLS * ROWS;

  AST_RAM_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o)); // R6
  AST_RAM_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> (int'(mem_addr_o) < CELLS)); // R2
  AST_SCROLL_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (mem_we_o && (int'(mem_addr_o) == int'($past(mem_addr_o)) - COLS))); // R6
  AST_CURS_HI_THEN_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (curs_we_o && curs_idx_o == 8'd14) |=> (curs_we_o && curs_idx_o == 8'd15)); // R7
  AST_CURS_LO_AFTER_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (curs_we_o && curs_idx_o == 8'd15) |-> $past(curs_we_o && curs_idx_o == 8'd14)); // R7
  AST_CURS_HI_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (curs_we_o && curs_idx_o == 8'd14) |-> (int'(curs_data_o) <= ((CELLS - 1) >> 8))); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o || curs_we_o) |-> !chr_ready_o); // R10
  AST_CLEAR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !chr_ready_o); // R8
endmodule

bind con_writer con_writer_chk #(.COLS(COLS), .ROWS(ROWS), .AW(AW)) i_con_writer_chk (.*);

// File: tb/test_con_writer.sv
`timescale 1ns/1ps
module test_con_writer;
  localparam int COLS  = 80;
  localparam int ROWS  = 25;
  localparam int CELLS = COLS * ROWS;
  localparam int AW    = $clog2(CELLS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chr_valid = 1'b0;
  logic [7:0] chr = '0;
  logic chr_ready;
  logic clr = 1'b0;
  logic attr_we = 1'b0;
  logic [7:0] attr = '0;
  logic mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic curs_we;
  logic [7:0] curs_idx, curs_data;

  always #5 clk = ~clk;

  con_writer i_con_writer (
    .clk_i(clk), .rst_ni(rst_n), .chr_valid_i(chr_valid), .chr_i(chr),
    .chr_ready_o(chr_ready), .clr_i(clr), .attr_we_i(attr_we), .attr_i(attr),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .curs_we_o(curs_we),
    .curs_idx_o(curs_idx), .curs_data_o(curs_data)
  );

  logic [15:0] ram [CELLS];
  logic [15:0] exp_mem [CELLS];

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  int errs = 0, checks = 0, cwr = 0;
  logic [7:0] cur_hi = '0, cur_lo = '0;
  int e_row = 0, e_col = 0;
  logic [7:0] e_attr = 8'h07;
  bit seen_busy = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (curs_we) begin
      if (curs_idx == 8'd14) cur_hi <= curs_data;
      else if (curs_idx == 8'd15) cur_lo <= curs_data;
      cwr <= cwr + 1;
    end
  end

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  function automatic void model_scroll();
    for (int i = 0; i < CELLS - COLS; i++) exp_mem[i] = exp_mem[i + COLS];
    for (int i = CELLS - COLS; i < CELLS; i++) exp_mem[i] = {e_attr, 8'h20};
    e_row = ROWS - 1;
  endfunction

  function automatic bit model_char(logic [7:0] ch);
    bit upd = 1;
    case (ch)
      8'h0A: begin e_col = 0; e_row++; end
      8'h0D: e_col = 0;
      8'h09: begin
        e_col = e_col + 8 - e_col % 8;
        if (e_col >= COLS) begin e_col = 0; e_row++; end
      end
      8'h07: ;
      8'h08: if (e_col > 0) e_col--; else upd = 0;
      default: begin
        exp_mem[e_row * COLS + e_col] = {e_attr, ch};
        e_col++;
        if (e_col >= COLS) begin e_col = 0; e_row++; end
      end
    endcase
    if (e_row > ROWS - 1) model_scroll();
    return upd;
  endfunction

  task automatic wait_idle();
    while (!chr_ready) @(negedge clk);
  endtask

  task automatic chk_cursor(int c0, bit upd, string req);
    int off = e_row * COLS + e_col;
    if (upd) begin
      chk(cwr == c0 + 2, req, "R7 cursor write count", cwr - c0, 2);
      chk({cur_hi, cur_lo} == 16'(off), req, "R7 cursor offset", int'({cur_hi, cur_lo}), off);
    end else begin
      chk(cwr == c0, req, "R5 cursor writes on ignored char", cwr - c0, 0);
    end
  endtask

  task automatic send(logic [7:0] ch, string req, bit do_attr = 0, logic [7:0] na = 8'h00);
    int c0;
    bit upd;
    @(negedge clk);
    c0 = cwr;
    upd = model_char(ch);
    chr_valid = 1'b1;
    chr = ch;
    if (do_attr) begin attr_we = 1'b1; attr = na; end
    @(negedge clk);
    chr_valid = 1'b0;
    attr_we = 1'b0;
    seen_busy = !chr_ready;
    if (do_attr) e_attr = na;
    wait_idle();
    chk_cursor(c0, upd, req);
  endtask

  task automatic clear(string req, bit with_char, logic [7:0] ch);
    int c0;
    @(negedge clk);
    c0 = cwr;
    clr = 1'b1;
    if (with_char) begin chr_valid = 1'b1; chr = ch; end
    @(negedge clk);
    clr = 1'b0;
    chr_valid = 1'b0;
    for (int i = 0; i < CELLS; i++) exp_mem[i] = {e_attr, 8'h20};
    e_row = 0;
    e_col = 0;
    wait_idle();
    chk_cursor(c0, 1, req);
  endtask

  task automatic chk_screen(string req);
    int bad = 0, first = -1;
    for (int i = 0; i < CELLS; i++)
      if (ram[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, req, $sformatf("screen cells wrong (first at %0d)", first), bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7001));
    for (int i = 0; i < CELLS; i++) begin ram[i] = 16'h0000; exp_mem[i] = 16'h0000; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(chr_ready == 1'b1, "R1", "ready after reset", int'(chr_ready), 1);
    chk(curs_we == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1", "idle strobes",
        int'({curs_we, mem_we, mem_re}), 0);

    // R1 R2: first char at cell 0 with reset attribute
    send(8'h41, "R1");
    chk_screen("R1");

    clear("R8", 0, 8'h00);
    chk_screen("R8");

    // R5: backspace at column 0, then normal backspace and bell
    send(8'h08, "R5");
    send(8'h78, "R5");
    send(8'h79, "R5");
    send(8'h08, "R5");
    send(8'h07, "R5");
    chk_screen("R5");

    // R3
    send(8'h0D, "R3");
    send(8'h0A, "R3");

    // R4: tab stops and wrap at line end
    for (int i = 0; i < 9; i++) send(8'h09, "R4");
    for (int i = 0; i < 3; i++) send(8'h7A, "R4");
    send(8'h09, "R4");
    chk(e_col == 0 && e_row == 2, "R4", "model tab wrap", e_col, 0);

    // R2: a full line of printables wraps
    for (int i = 0; i < COLS + 2; i++) send(8'h30 + 8'(i % 10), "R2");
    chk_screen("R2");

    // R9: attribute change in the same cycle as a character
    send(8'h51, "R9", 1, 8'h1E);
    send(8'h52, "R9");
    chk_screen("R9");

    // R6 R10: line feed on the last row scrolls
    while (e_row < ROWS - 1) send(8'h0A, "R6");
    send(8'h4C, "R6");
    send(8'h0A, "R6");
    chk(seen_busy == 1'b1, "R10", "ready low during scroll", int'(!seen_busy), 0);
    chk_screen("R6");

    // R6: printable wrap on the last row scrolls, fill uses new attribute
    send(8'h0D, "R6", 1, 8'h4F);
    for (int i = 0; i < COLS; i++) send(8'h61 + 8'(i % 26), "R6");
    chk_screen("R6");

    // R8: clear and character in the same cycle
    clear("R8", 1, 8'h5A);
    chk_screen("R8");

    // random stream
    for (int n = 0; n < 200; n++) begin
      int r = $urandom_range(99, 0);
      logic [7:0] ch;
      if (r < 8) ch = 8'h0A;
      else if (r < 12) ch = 8'h0D;
      else if (r < 17) ch = 8'h09;
      else if (r < 22) ch = 8'h08;
      else if (r < 24) ch = 8'h07;
      else ch = 8'h21 + 8'($urandom_range(93, 0));
      if ($urandom_range(9, 0) == 0) send(ch, "R9", 1, 8'($urandom_range(255, 0)));
      else send(ch, "R2");
    end
    chk_screen("R6");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule